// File: doc/BRIEF.md
# Multi-Zone Automatic Fan PWM Controller

This block turns a set of signed temperature readings into PWM drive for a group of cooling fans, one output per zone. Each sensor reading can be steered into any mix of zones. A zone's temperature is the hottest reading assigned to it. Each zone's fan then follows a programmable curve. Below the zone's fan limit the fan holds a floor duty, or it stops if the zone is set to stop there. Above the limit, duty climbs in a straight line and reaches full duty at limit plus span.

The configuration comes in on plain input ports and is sampled continuously. A critical temperature shared by all zones overrides everything: when any zone runs hotter than it, every fan runs at full duty. A quiet mode holds every fan at or below a cap duty to keep acoustic noise down. In quiet mode a select input decides where the cap is released. The cap can give way as soon as a zone reaches its own limit plus span, or it can hold until the critical temperature is exceeded.

Each output is produced by comparing a free-running period counter with a duty register. Duty registers only reload at the period boundary, so each PWM period is cut from one duty value.

Top module: `fan_zone_pwm`

## Requirements
- R1: Temperatures are 8-bit two's-complement whole degrees. A zone's temperature is the signed maximum of every sensor s whose mask bit `sens_zone[s*NZ+z]` is set. A zone with no assigned sensor reads -128.
- R2: With the critical override inactive, a zone strictly below its fan limit gets its floor duty when its stop bit is 0, and duty 0 when its stop bit is 1. At exactly the limit the duty equals the floor, regardless of the stop bit.
- R3: For a zone at or above its limit with span S > 0, and difference D = T - limit < S, the duty is floor + floor(D*(255-floor)/S). For D >= S the duty is 255.
- R4: A span of 0 gives duty 255 as soon as the temperature reaches the limit.
- R5: If any zone's temperature is strictly greater than `crit_lim`, every zone's duty becomes 255, in both modes. A temperature equal to `crit_lim` does not trigger this.
- R6: With `quiet_mode`=1, each zone's duty is the smaller of its normal duty (R2 to R4) and `quiet_cap`. This also applies to the floor.
- R7: In quiet mode with `quiet_hi_sel`=1, a zone whose temperature is at or above limit plus span gets 255. With `quiet_hi_sel`=0, the cap stays in force until the critical override of R5 applies.
- R8: In any 256 consecutive clocks, a PWM output is high for exactly duty cycles when duty < 255, and for all 256 when duty = 255. A duty of 0 keeps the output low.
- R9: The 8-bit period counter is 0 in reset and counts up by one every clock, wrapping 255 to 0. `duty_o` changes only on the edge where the counter wraps, and takes the target computed from the inputs present on that edge.
- R10: During reset and until the first counter wrap, every `duty_o` field is 0 and every `pwm_o` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sens_temp | input | NS*TW | Signed sensor readings, sensor s in bits [s*TW +: TW] |
| sens_zone | input | NS*NZ | Per-sensor zone mask, sensor s in bits [s*NZ +: NZ] |
| fan_lim | input | NZ*TW | Signed fan limit per zone |
| ramp_span | input | NZ*TW | Unsigned ramp span per zone |
| floor_duty | input | NZ*DW | Floor duty per zone |
| stop_below | input | NZ | Per-zone stop-below-limit select |
| crit_lim | input | TW | Signed critical temperature shared by all zones |
| quiet_mode | input | 1 | 1 selects capped quiet mode |
| quiet_hi_sel | input | 1 | Quiet mode: 1 releases at limit plus span, 0 only at the critical limit |
| quiet_cap | input | DW | Duty cap in quiet mode |
| duty_o | output | NZ*DW | Registered duty per zone |
| pwm_o | output | NZ | PWM output per zone |

## Verification
The hardest case to reach from the ports is the period-boundary rule. It only shows when the temperature moves partway through a period, and the counter phase cannot be seen at the outputs. The bench rebuilds the phase from reset, using the counting rule of R9. It changes a reading at a known mid-period clock and checks that `duty_o` keeps its old value up to the clock before the wrap. It then checks that the new value appears exactly on the wrap. Multi-sensor zones, negative readings, ties at the limit and at the critical temperature, and both quiet release choices are each reached by loading a deliberate configuration. Every scenario is scored on both the duty value and the measured high time of the PWM output.

// File: rtl/fan_zone_pwm.sv
module fan_zone_pwm #(
  parameter int NZ = 4,
  parameter int NS = 4,
  parameter int TW = 8,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NS*TW-1:0]   sens_temp,
  input  logic [NS*NZ-1:0]   sens_zone,
  input  logic [NZ*TW-1:0]   fan_lim,
  input  logic [NZ*TW-1:0]   ramp_span,
  input  logic [NZ*DW-1:0]   floor_duty,
  input  logic [NZ-1:0]      stop_below,
  input  logic [TW-1:0]      crit_lim,
  input  logic               quiet_mode,
  input  logic               quiet_hi_sel,
  input  logic [DW-1:0]      quiet_cap,
  output logic [NZ*DW-1:0]   duty_o,
  output logic [NZ-1:0]      pwm_o
);
  localparam logic [DW-1:0] FULL = '1;
  localparam int PW = TW + DW;
  localparam int XW = TW + 2;

  logic [DW-1:0]    cnt_q;
  logic [NZ*DW-1:0] duty_q;
  logic [NZ*DW-1:0] tgt;
  logic [NZ-1:0]    hot;
  logic             ovr;

  assign ovr = |hot;

  for (genvar z = 0; z < NZ; z++) begin : g_zone
    logic signed [TW-1:0] zt;
    logic [TW-1:0]        lim, span;
    logic [DW-1:0]        fl, ramp, lin, capped;
    logic [XW-1:0]        d;
    logic [PW-1:0]        prod, quo, sum;
    logic                 below, at_full;

    always_comb begin
      zt = {1'b1, {(TW-1){1'b0}}};
      for (int s = 0; s < NS; s++)
        if (sens_zone[s*NZ+z] && $signed(sens_temp[s*TW +: TW]) > zt)
          zt = sens_temp[s*TW +: TW];
    end

    assign lim     = fan_lim[z*TW +: TW];
    assign span    = ramp_span[z*TW +: TW];
    assign fl      = floor_duty[z*DW +: DW];
    assign d       = {{2{zt[TW-1]}}, zt} - {{2{lim[TW-1]}}, lim};
    assign below   = d[XW-1];
    assign at_full = !below && (d >= {2'b00, span});
    assign prod    = {{DW{1'b0}}, d[TW-1:0]} * {{TW{1'b0}}, FULL - fl};
    assign quo     = (span == '0) ? '1 : prod / {{DW{1'b0}}, span};
    assign sum     = {{TW{1'b0}}, fl} + quo;
    assign ramp    = (at_full || sum > {{TW{1'b0}}, FULL}) ? FULL : sum[DW-1:0];
    assign lin     = below ? (stop_below[z] ? '0 : fl) : ramp;
    assign capped  = (lin > quiet_cap) ? quiet_cap : lin;
    assign hot[z]  = zt > $signed(crit_lim);

    assign tgt[z*DW +: DW] = ovr ? FULL :
                             !quiet_mode ? lin :
                             (quiet_hi_sel && at_full) ? FULL : capped;

    assign pwm_o[z] = (duty_q[z*DW +: DW] == FULL) || (cnt_q < duty_q[z*DW +: DW]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == FULL) duty_q <= tgt;
    end
  end

  assign duty_o = duty_q;
endmodule

module fan_zone_pwm_chk #(
  parameter int NZ = 4,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DW-1:0]    cnt,
  input logic [NZ*DW-1:0] duty,
  input logic [NZ-1:0]    pwm,
  input logic             ovr
);
  localparam logic [DW-1:0] FULL = '1;

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == FULL |=> cnt == '0); // R9

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0 |-> $stable(duty)); // R9

  AST_OVR_ALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && ovr) |=> duty == '1); // R5

  for (genvar z = 0; z < NZ; z++) begin : g_chk
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      duty[z*DW +: DW] == '0 |-> !pwm[z]); // R8
    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && duty[z*DW +: DW] != '0) |-> pwm[z]); // R8
  end
endmodule

bind fan_zone_pwm fan_zone_pwm_chk #(.NZ(NZ), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .duty(duty_q), .pwm(pwm_o), .ovr(ovr)
);

// File: tb/sim_fan_zone_pwm.sv
module sim_fan_zone_pwm;
  localparam int NZ = 4, NS = 4, TW = 8, DW = 8;

  logic clk = 0, rst_n = 0;
  logic [NS*TW-1:0] sens_temp = '0;
  logic [NS*NZ-1:0] sens_zone = '0;
  logic [NZ*TW-1:0] fan_lim = '0, ramp_span = '0;
  logic [NZ*DW-1:0] floor_duty = '0;
  logic [NZ-1:0]    stop_below = '0;
  logic [TW-1:0]    crit_lim = 8'd100;
  logic             quiet_mode = 0, quiet_hi_sel = 0;
  logic [DW-1:0]    quiet_cap = '0;
  logic [NZ*DW-1:0] duty_o;
  logic [NZ-1:0]    pwm_o;

  fan_zone_pwm #(.NZ(NZ), .NS(NS), .TW(TW), .DW(DW)) u0 (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] ph = 0;
  always @(posedge clk) ph <= rst_n ? ph + 8'd1 : 8'd0;

  int tmp[NS], msk[NS], lim[NZ], spn[NZ], flr[NZ], stp[NZ];
  int crit = 100, qm = 0, qhs = 0, cap = 0;

  typedef struct { int z; int d; string tag; } item_t;
  item_t sb[$];
  bit mon_req = 0;

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int zone_t(int z);
    int best = -128;
    for (int s = 0; s < NS; s++)
      if (msk[s][z] && tmp[s] > best) best = tmp[s];
    return best;
  endfunction

  function automatic int model(int z);
    int t = zone_t(z), dd, base;
    for (int k = 0; k < NZ; k++) if (zone_t(k) > crit) return 255;
    dd = t - lim[z];
    if (dd < 0) base = stp[z] ? 0 : flr[z];
    else if (dd >= spn[z]) base = 255;
    else base = flr[z] + (dd * (255 - flr[z])) / spn[z];
    if (qm == 0) return base;
    if (qhs && dd >= 0 && dd >= spn[z]) return 255;
    return base < cap ? base : cap;
  endfunction

  task automatic drive();
    for (int s = 0; s < NS; s++) begin
      sens_temp[s*TW +: TW] = tmp[s][7:0];
      sens_zone[s*NZ +: NZ] = msk[s][3:0];
    end
    for (int z = 0; z < NZ; z++) begin
      fan_lim[z*TW +: TW]    = lim[z][7:0];
      ramp_span[z*TW +: TW]  = spn[z][7:0];
      floor_duty[z*DW +: DW] = flr[z][7:0];
      stop_below[z]          = stp[z][0];
    end
    crit_lim = crit[7:0]; quiet_mode = qm[0]; quiet_hi_sel = qhs[0]; quiet_cap = cap[7:0];
  endtask

  task automatic scenario(string tag);
    @(negedge clk);
    drive();
    for (int z = 0; z < NZ; z++) sb.push_back('{z, model(z), tag});
    repeat (512) @(negedge clk);
    mon_req = 1;
    wait (mon_req == 0);
  endtask

  initial begin : monitor
    forever begin
      int hi[NZ];
      item_t it[NZ];
      wait (mon_req == 1);
      for (int z = 0; z < NZ; z++) begin
        it[z] = sb.pop_front();
        hi[z] = 0;
        chk(it[z].tag, int'(duty_o[it[z].z*DW +: DW]), it[z].d, $sformatf("duty zone%0d", it[z].z));
      end
      for (int c = 0; c < 256; c++) begin
        for (int z = 0; z < NZ; z++) hi[z] += int'(pwm_o[z]);
        @(negedge clk);
      end
      for (int z = 0; z < NZ; z++)
        chk("R8", hi[z], it[z].d == 255 ? 256 : it[z].d, $sformatf("pwm high count zone%0d", z));
      mon_req = 0;
    end
  end

  task automatic base_cfg();
    for (int i = 0; i < 4; i++) begin
      msk[i] = 1 << i; lim[i] = 40; spn[i] = 20; flr[i] = 64; stp[i] = 0; tmp[i] = 0;
    end
    crit = 100; qm = 0; qhs = 0; cap = 128;
  endtask

  initial begin : driver
    int old0;
    base_cfg();
    drive();
    repeat (3) @(negedge clk);
    chk("R10", int'(duty_o), 0, "duty in reset");
    chk("R10", int'(pwm_o), 0, "pwm in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R10", int'(duty_o), 0, "duty after reset");
    chk("R10", int'(pwm_o), 0, "pwm after reset");

    tmp = '{30, 40, 50, 70};                 scenario("R3");
    stp = '{1, 1, 0, 0}; tmp = '{30, 40, 39, 60}; scenario("R2");
    base_cfg();
    lim = '{-10, -10, -10, -10}; flr = '{0, 0, 0, 0}; spn = '{10, 10, 10, 10};
    tmp = '{-20, -5, -10, 0};                scenario("R3");
    base_cfg();
    spn = '{0, 0, 0, 0}; tmp = '{40, 39, 90, -50}; scenario("R4");
    base_cfg();
    msk = '{1, 1, 1, 6}; tmp = '{45, 55, -3, 47};  scenario("R1");
    stp = '{0, 0, 0, 1};                            scenario("R1");
    base_cfg();
    tmp = '{30, 40, 50, 101};                scenario("R5");
    tmp = '{30, 40, 50, 100};                scenario("R5");
    qm = 1; qhs = 0; cap = 128;
    tmp = '{50, 70, 30, 99};                 scenario("R6");
    cap = 40;  tmp = '{30, 45, 10, 0};       scenario("R6");
    cap = 128; qhs = 1; tmp = '{60, 59, 61, 30}; scenario("R7");
    qhs = 0;  tmp = '{60, 59, 61, 30};       scenario("R7");
    tmp = '{60, 59, 61, 105};                scenario("R5");

    base_cfg();
    tmp = '{50, 50, 50, 50};
    scenario("R9");
    old0 = model(0);
    while (ph != 8'd100) @(negedge clk);
    tmp[0] = 70; drive();
    @(negedge clk);
    chk("R9", int'(duty_o[7:0]), old0, "duty mid-period");
    while (ph != 8'd255) @(negedge clk);
    chk("R9", int'(duty_o[7:0]), old0, "duty before wrap");
    @(negedge clk);
    chk("R9", int'(ph), 0, "phase at wrap");
    chk("R9", int'(duty_o[7:0]), 255, "duty after wrap");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule